// File: doc/BRIEF.md
# SYNC Residence-Time Correction Unit

This block sits in a two-port ring node that acts as a transparent clock. When a SYNC time message comes in on one ring port, the block keeps its ingress timestamp and sequence number. When the same message leaves on the opposite port, it takes the egress timestamp, works out how long the message stayed in the node, and adds that time to the message's correction field. The adjusted correction goes to the egress frame modifier, which writes it into the frame as it leaves (one-step operation, no follow-up message). Both timestamps come from a free-running 48-bit nanosecond counter. The correction field is 64 bits wide, in units of 2^-16 ns.

Storage for ingress times is chosen at run time. In multicast mode each direction sees one SYNC per round, so one register per direction is enough. In unicast mode SYNCs for many slaves arrive in series, so ingress entries go through a FIFO that is as deep as the ring has nodes. The egress side checks each stored entry against the departing message's sequence number.

In peer-to-peer mode the block also adds the measured delay of the link the SYNC came in on. Software loads that delay into one register per port. Peer-delay messages are flagged as link-local so that the switch does not forward them along the ring.

Top module: `tc_residence_unit`

## Requirements
- R1: After reset, `corr_vld`, `seq_err`, `fifo_ovf` and `no_fwd` are low, the FIFO is empty, both direction registers are empty and both link delays are zero.
- R2: For an egress SYNC (message type 0x0) whose stored entry matches, `corr_out` = `egr_corr_in` + ((`egr_ts` − stored ingress ts) mod 2^48) × 2^16, modulo 2^64. It is presented with `corr_vld` high in the cycle after the egress strobe.
- R3: In multicast mode (`unicast_mode`=0) each ingress port holds one entry, and a newer SYNC on that port overwrites the older one. An egress SYNC on port q uses the entry of the other port (1−q) and consumes it.
- R4: In unicast mode ingress SYNCs enter a FIFO of DEPTH entries (default 50). Egress SYNCs use and remove them in arrival order, whatever the port.
- R5: An ingress SYNC in unicast mode that arrives while the FIFO already holds DEPTH entries is dropped. `fifo_ovf` pulses high in the next cycle. A simultaneous pop does not make room for it.
- R6: If the stored entry's sequence number differs from `egr_seq`, or no entry exists, `seq_err` and `corr_vld` pulse together and `corr_out` equals `egr_corr_in` unchanged. A mismatched FIFO entry is still removed.
- R7: With `p2p_mode`=1, a matched correction also gains (link delay of the ingress-side port 1−q) × 2^16. With `p2p_mode`=0 no link delay is added.
- R8: A cycle with `ld_wr`=1 loads `ld_val` into the link-delay register of port `ld_sel`.
- R9: An ingress strobe with message type 0x2, 0x3 or 0xA (peer-delay messages) raises `no_fwd` in the next cycle, and such a message is never stored. Any other type leaves `no_fwd` low.
- R10: An egress strobe whose type is not SYNC produces no `corr_vld` and leaves storage untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unicast_mode | input | 1 | 1: FIFO storage, 0: one register per direction |
| p2p_mode | input | 1 | 1: add the ingress-link delay |
| ld_wr | input | 1 | Link-delay register write strobe |
| ld_sel | input | 1 | Port whose link delay is written |
| ld_val | input | 32 | Link delay in ns |
| ing_stb | input | 1 | Ingress timestamp strobe |
| ing_port | input | 1 | Ring port of arrival |
| ing_type | input | 4 | Message type of ingress message |
| ing_seq | input | 16 | Sequence number of ingress message |
| ing_ts | input | 48 | Ingress timestamp, ns |
| egr_stb | input | 1 | Egress timestamp strobe |
| egr_port | input | 1 | Ring port of departure |
| egr_type | input | 4 | Message type of egress message |
| egr_seq | input | 16 | Sequence number of egress message |
| egr_ts | input | 48 | Egress timestamp, ns |
| egr_corr_in | input | 64 | Correction field as received, 2^-16 ns |
| corr_vld | output | 1 | Correction result valid |
| corr_out | output | 64 | Updated correction field |
| seq_err | output | 1 | Missing or mismatched stored entry |
| fifo_ovf | output | 1 | Ingress SYNC dropped, FIFO full |
| no_fwd | output | 1 | Last ingress message is link-local |

## Verification
On every cycle the assertions check timing and consistency: a correction appears exactly one cycle after an egress SYNC and never otherwise, an error result always carries the incoming correction unchanged, an overflow pulse only follows an ingress SYNC into a full FIFO, the FIFO occupancy never exceeds its depth, and the link-local flag only follows a non-SYNC ingress. The arithmetic can only be shown by the bench's scenarios: residence values across counter wrap, overwrite and direction selection, FIFO ordering, the dropped entry on overflow, sequence mismatches, and whether the link delay is added.

// File: rtl/tcru_pkg.sv
package tcru_pkg;
  localparam int TS_W   = 48;
  localparam int SEQ_W  = 16;
  localparam int CORR_W = 64;
  localparam int LD_W   = 32;
  localparam int TYPE_W = 4;
  localparam int FRAC_W = 16;
  localparam int NPORT  = 2;

  localparam logic [TYPE_W-1:0] MT_SYNC     = 4'h0;
  localparam logic [TYPE_W-1:0] MT_PD_REQ   = 4'h2;
  localparam logic [TYPE_W-1:0] MT_PD_RESP  = 4'h3;
  localparam logic [TYPE_W-1:0] MT_PD_RFUP  = 4'hA;

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic [TS_W-1:0]  ts;
  } ts_entry_t;

  localparam int ENTRY_W = $bits(ts_entry_t);

  // Correction update: residence (mod 2^TS_W) plus optional link delay,
  // both scaled to sub-nanosecond units.
  function automatic logic [CORR_W-1:0] add_residence(
      input logic [CORR_W-1:0] cin,
      input logic [TS_W-1:0]   t_out,
      input logic [TS_W-1:0]   t_in,
      input logic [LD_W-1:0]   link_dly,
      input logic              use_link);
    logic [TS_W-1:0]   res;
    logic [CORR_W-1:0] acc;
    res = t_out - t_in;
    acc = cin + {res, {FRAC_W{1'b0}}};
    if (use_link)
      acc = acc + {{(CORR_W-LD_W-FRAC_W){1'b0}}, link_dly, {FRAC_W{1'b0}}};
    return acc;
  endfunction

  function automatic logic is_link_local(input logic [TYPE_W-1:0] t);
    return (t == MT_PD_REQ) || (t == MT_PD_RESP) || (t == MT_PD_RFUP);
  endfunction
endpackage

// File: rtl/tcru_ts_fifo.sv
module tcru_ts_fifo #(
  parameter int DEPTH = 50,
  parameter int W     = 64,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tcru_dir_slot.sv
module tcru_dir_slot
  import tcru_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  ts_entry_t wr_entry,
  input  logic      clr,
  output logic      valid,
  output ts_entry_t entry
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      entry <= '0;
    end else if (wr) begin
      valid <= 1'b1;
      entry <= wr_entry;
    end else if (clr) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tc_residence_unit.sv
module tc_residence_unit
  import tcru_pkg::*;
#(
  parameter int DEPTH = 50,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unicast_mode,
  input  logic              p2p_mode,
  input  logic              ld_wr,
  input  logic              ld_sel,
  input  logic [LD_W-1:0]   ld_val,
  input  logic              ing_stb,
  input  logic              ing_port,
  input  logic [TYPE_W-1:0] ing_type,
  input  logic [SEQ_W-1:0]  ing_seq,
  input  logic [TS_W-1:0]   ing_ts,
  input  logic              egr_stb,
  input  logic              egr_port,
  input  logic [TYPE_W-1:0] egr_type,
  input  logic [SEQ_W-1:0]  egr_seq,
  input  logic [TS_W-1:0]   egr_ts,
  input  logic [CORR_W-1:0] egr_corr_in,
  output logic              corr_vld,
  output logic [CORR_W-1:0] corr_out,
  output logic              seq_err,
  output logic              fifo_ovf,
  output logic              no_fwd
);
  // Named events, visible to the checker
  logic      ing_sync, egr_sync, src_dir;
  logic      fifo_push, fifo_pop, fifo_empty, fifo_full, ovf_evt;
  logic [CW-1:0] fifo_count;
  ts_entry_t fifo_head, new_entry, hit_entry;
  logic      hit, seq_match;
  logic [NPORT-1:0] slot_wr, slot_clr, slot_vld;
  ts_entry_t slot_ent [NPORT];
  logic [LD_W-1:0] link_dly [NPORT];
  logic [CORR_W-1:0] corr_nxt;

  assign ing_sync  = ing_stb && (ing_type == MT_SYNC);
  assign egr_sync  = egr_stb && (egr_type == MT_SYNC);
  assign src_dir   = ~egr_port;
  assign new_entry = '{seq: ing_seq, ts: ing_ts};

  assign fifo_push = ing_sync && unicast_mode;
  assign ovf_evt   = fifo_push && fifo_full;
  assign fifo_pop  = egr_sync && unicast_mode;

  tcru_ts_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .din   (new_entry),
    .dout  (fifo_head),
    .empty (fifo_empty),
    .full  (fifo_full),
    .count (fifo_count)
  );

  for (genvar d = 0; d < NPORT; d++) begin : g_dir
    assign slot_wr[d]  = ing_sync && !unicast_mode && (ing_port == d[0]);
    assign slot_clr[d] = egr_sync && !unicast_mode && (src_dir == d[0]);

    tcru_dir_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (slot_wr[d]),
      .wr_entry (new_entry),
      .clr      (slot_clr[d]),
      .valid    (slot_vld[d]),
      .entry    (slot_ent[d])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)                        link_dly[d] <= '0;
      else if (ld_wr && ld_sel == d[0])  link_dly[d] <= ld_val;
    end
  end

  always_comb begin
    if (unicast_mode) begin
      hit       = !fifo_empty;
      hit_entry = fifo_head;
    end else begin
      hit       = slot_vld[src_dir];
      hit_entry = slot_ent[src_dir];
    end
  end

  assign seq_match = hit && (hit_entry.seq == egr_seq);
  assign corr_nxt  = seq_match
                   ? add_residence(egr_corr_in, egr_ts, hit_entry.ts,
                                   link_dly[src_dir], p2p_mode)
                   : egr_corr_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corr_vld <= 1'b0;
      corr_out <= '0;
      seq_err  <= 1'b0;
      fifo_ovf <= 1'b0;
      no_fwd   <= 1'b0;
    end else begin
      corr_vld <= egr_sync;
      seq_err  <= egr_sync && !seq_match;
      if (egr_sync) corr_out <= corr_nxt;
      fifo_ovf <= ovf_evt;
      no_fwd   <= ing_stb && is_link_local(ing_type);
    end
  end
endmodule

// File: rtl/tcru_checker.sv
module tcru_checker #(
  parameter int DEPTH = 50,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          unicast_mode,
  input logic          ing_sync,
  input logic          egr_sync,
  input logic          ing_stb,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_count,
  input logic [63:0]   egr_corr_in,
  input logic          corr_vld,
  input logic [63:0]   corr_out,
  input logic          seq_err,
  input logic          fifo_ovf,
  input logic          no_fwd
);
  assert_corr_after_egress_R2: assert property (@(posedge clk) disable iff (!rst_n)
    egr_sync |=> corr_vld);

  assert_no_spurious_corr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    corr_vld |-> $past(egr_sync));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  assert_ovf_only_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |-> $past(fifo_full && ing_sync && unicast_mode));

  assert_err_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> (corr_vld && corr_out == $past(egr_corr_in)));

  assert_link_local_R9: assert property (@(posedge clk) disable iff (!rst_n)
    no_fwd |-> $past(ing_stb && !ing_sync));
endmodule

bind tc_residence_unit tcru_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .unicast_mode (unicast_mode),
  .ing_sync     (ing_sync),
  .egr_sync     (egr_sync),
  .ing_stb      (ing_stb),
  .fifo_full    (fifo_full),
  .fifo_count   (fifo_count),
  .egr_corr_in  (egr_corr_in),
  .corr_vld     (corr_vld),
  .corr_out     (corr_out),
  .seq_err      (seq_err),
  .fifo_ovf     (fifo_ovf),
  .no_fwd       (no_fwd)
);

// File: tb/tc_residence_unit_tb.sv
module tc_residence_unit_tb;
  localparam int DEPTH = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic unicast_mode = 1'b0, p2p_mode = 1'b0;
  logic ld_wr = 1'b0, ld_sel = 1'b0;
  logic [31:0] ld_val = '0;
  logic ing_stb = 1'b0, ing_port = 1'b0;
  logic [3:0] ing_type = '0;
  logic [15:0] ing_seq = '0;
  logic [47:0] ing_ts = '0;
  logic egr_stb = 1'b0, egr_port = 1'b0;
  logic [3:0] egr_type = '0;
  logic [15:0] egr_seq = '0;
  logic [47:0] egr_ts = '0;
  logic [63:0] egr_corr_in = '0;
  logic corr_vld, seq_err, fifo_ovf, no_fwd;
  logic [63:0] corr_out;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tc_residence_unit #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .unicast_mode(unicast_mode), .p2p_mode(p2p_mode),
    .ld_wr(ld_wr), .ld_sel(ld_sel), .ld_val(ld_val),
    .ing_stb(ing_stb), .ing_port(ing_port), .ing_type(ing_type),
    .ing_seq(ing_seq), .ing_ts(ing_ts),
    .egr_stb(egr_stb), .egr_port(egr_port), .egr_type(egr_type),
    .egr_seq(egr_seq), .egr_ts(egr_ts), .egr_corr_in(egr_corr_in),
    .corr_vld(corr_vld), .corr_out(corr_out), .seq_err(seq_err),
    .fifo_ovf(fifo_ovf), .no_fwd(no_fwd)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected correction: scale residence and delay by 65536 via multiply.
  function automatic logic [63:0] expect_corr(input logic [63:0] cin,
      input logic [47:0] t_out, input logic [47:0] t_in,
      input logic [31:0] dly, input bit with_dly);
    logic [47:0] span;
    logic [63:0] r;
    span = t_out - t_in;
    r = cin + 64'(span) * 64'd65536;
    if (with_dly) r = r + 64'(dly) * 64'd65536;
    return r;
  endfunction

  task automatic do_reset(input bit uni, input bit p2p);
    @(negedge clk);
    rst_n = 1'b0; unicast_mode = uni; p2p_mode = p2p;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ingress(input bit port, input logic [3:0] typ, input logic [15:0] seq,
                         input logic [47:0] ts, output bit ovf, output bit nf);
    @(negedge clk);
    ing_stb = 1'b1; ing_port = port; ing_type = typ; ing_seq = seq; ing_ts = ts;
    @(negedge clk);
    ovf = fifo_ovf; nf = no_fwd;
    ing_stb = 1'b0;
  endtask

  task automatic egress(input bit port, input logic [3:0] typ, input logic [15:0] seq,
                        input logic [47:0] ts, input logic [63:0] cin,
                        output bit vld, output bit err, output logic [63:0] cout);
    @(negedge clk);
    egr_stb = 1'b1; egr_port = port; egr_type = typ; egr_seq = seq;
    egr_ts = ts; egr_corr_in = cin;
    @(negedge clk);
    vld = corr_vld; err = seq_err; cout = corr_out;
    egr_stb = 1'b0;
  endtask

  task automatic write_delay(input bit port, input logic [31:0] v);
    @(negedge clk);
    ld_wr = 1'b1; ld_sel = port; ld_val = v;
    @(negedge clk);
    ld_wr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    check(!corr_vld && !seq_err && !fifo_ovf && !no_fwd, "R1 outputs idle",
          {60'd0, corr_vld, seq_err, fifo_ovf, no_fwd}, 64'd0);
  endtask

  task automatic t_multicast();
    bit o, n, v, e; logic [63:0] c, x;
    do_reset(1'b0, 1'b0);
    ingress(1'b0, 4'h0, 16'd5, 48'd1000, o, n);
    egress(1'b1, 4'h0, 16'd5, 48'd1750, 64'h100, v, e, c);
    x = expect_corr(64'h100, 48'd1750, 48'd1000, 32'd0, 1'b0);
    check(v && !e && c == x, "R2 basic residence", c, x);
    ingress(1'b0, 4'h0, 16'd6, 48'hFFFF_FFFF_FFF6, o, n);
    egress(1'b1, 4'h0, 16'd6, 48'd20, 64'h0, v, e, c);
    x = 64'd30 << 16;
    check(v && !e && c == x, "R2 counter wrap", c, x);
  endtask

  task automatic t_overwrite_direction();
    bit o, n, v, e; logic [63:0] c, x;
    do_reset(1'b0, 1'b0);
    ingress(1'b1, 4'h0, 16'd1, 48'd100, o, n);
    ingress(1'b1, 4'h0, 16'd2, 48'd300, o, n);
    egress(1'b0, 4'h0, 16'd2, 48'd400, 64'd0, v, e, c);
    x = 64'd100 << 16;
    check(v && !e && c == x, "R3 overwrite keeps newest", c, x);
    egress(1'b0, 4'h0, 16'd2, 48'd500, 64'h77, v, e, c);
    check(v && e && c == 64'h77, "R3 slot consumed, R6 passthru", c, 64'h77);
    ingress(1'b0, 4'h0, 16'd7, 48'd50, o, n);
    ingress(1'b1, 4'h0, 16'd7, 48'd80, o, n);
    egress(1'b0, 4'h0, 16'd7, 48'd200, 64'd0, v, e, c);
    x = 64'd120 << 16;
    check(v && !e && c == x, "R3 egress port0 uses port1 entry", c, x);
    egress(1'b1, 4'h0, 16'd7, 48'd200, 64'd0, v, e, c);
    x = 64'd150 << 16;
    check(v && !e && c == x, "R3 egress port1 uses port0 entry", c, x);
  endtask

  task automatic t_p2p();
    bit o, n, v, e; logic [63:0] c, x;
    do_reset(1'b0, 1'b1);
    write_delay(1'b0, 32'd25);
    write_delay(1'b1, 32'd40);
    ingress(1'b0, 4'h0, 16'd9, 48'd0, o, n);
    egress(1'b1, 4'h0, 16'd9, 48'd10, 64'd0, v, e, c);
    x = expect_corr(64'd0, 48'd10, 48'd0, 32'd25, 1'b1);
    check(v && !e && c == x, "R7 R8 port0 link delay added", c, x);
    ingress(1'b1, 4'h0, 16'd9, 48'd0, o, n);
    egress(1'b0, 4'h0, 16'd9, 48'd10, 64'd0, v, e, c);
    x = expect_corr(64'd0, 48'd10, 48'd0, 32'd40, 1'b1);
    check(v && !e && c == x, "R7 R8 port1 link delay added", c, x);
    @(negedge clk); p2p_mode = 1'b0;
    ingress(1'b0, 4'h0, 16'd10, 48'd0, o, n);
    egress(1'b1, 4'h0, 16'd10, 48'd10, 64'd0, v, e, c);
    x = 64'd10 << 16;
    check(v && !e && c == x, "R7 no delay without p2p", c, x);
  endtask

  task automatic t_unicast();
    bit o, n, v, e; logic [63:0] c, x;
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) ingress(1'(i), 4'h0, 16'(10 + i), 48'(100 * i), o, n);
    for (int i = 0; i < 3; i++) begin
      egress(1'b1, 4'h0, 16'(10 + i), 48'(100 * i + 7 + i), 64'd0, v, e, c);
      x = 64'(7 + i) << 16;
      check(v && !e && c == x, "R4 FIFO order", c, x);
    end
    ingress(1'b0, 4'h0, 16'd20, 48'd0, o, n);
    ingress(1'b0, 4'h0, 16'd21, 48'd5, o, n);
    egress(1'b1, 4'h0, 16'd21, 48'd50, 64'h55, v, e, c);
    check(v && e && c == 64'h55, "R6 mismatch discards head", c, 64'h55);
    egress(1'b1, 4'h0, 16'd21, 48'd50, 64'd0, v, e, c);
    x = 64'd45 << 16;
    check(v && !e && c == x, "R6 next entry matches", c, x);
    egress(1'b1, 4'h0, 16'd22, 48'd60, 64'h9, v, e, c);
    check(v && e && c == 64'h9, "R6 empty FIFO error", c, 64'h9);
  endtask

  task automatic t_nonsync_egress();
    bit o, n, v, e; logic [63:0] c, x;
    do_reset(1'b1, 1'b0);
    ingress(1'b0, 4'h0, 16'd30, 48'd10, o, n);
    egress(1'b1, 4'h1, 16'd30, 48'd90, 64'd0, v, e, c);
    check(!v && !e, "R10 non-SYNC egress no result", {62'd0, v, e}, 64'd0);
    egress(1'b1, 4'h0, 16'd30, 48'd90, 64'd0, v, e, c);
    x = 64'd80 << 16;
    check(v && !e && c == x, "R10 entry untouched", c, x);
  endtask

  task automatic t_overflow();
    bit o, n, v, e; logic [63:0] c; int bad_ovf = 0, bad_pop = 0;
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      ingress(1'b0, 4'h0, 16'(i), 48'(i), o, n);
      if (o) bad_ovf++;
    end
    check(bad_ovf == 0, "R5 no overflow up to DEPTH", 64'(bad_ovf), 64'd0);
    ingress(1'b0, 4'h0, 16'd999, 48'd0, o, n);
    check(o, "R5 overflow pulse when full", {63'd0, o}, 64'd1);
    for (int i = 0; i < DEPTH; i++) begin
      egress(1'b1, 4'h0, 16'(i), 48'(i + 3), 64'd0, v, e, c);
      if (!v || e || c != (64'd3 << 16)) bad_pop++;
    end
    check(bad_pop == 0, "R4 R5 all DEPTH entries intact", 64'(bad_pop), 64'd0);
    egress(1'b1, 4'h0, 16'd999, 48'd5, 64'h3, v, e, c);
    check(v && e, "R5 dropped entry absent", {63'd0, e}, 64'd1);
  endtask

  task automatic t_link_local();
    bit o, n, v, e; logic [63:0] c;
    do_reset(1'b0, 1'b0);
    ingress(1'b0, 4'h2, 16'd40, 48'd0, o, n);
    check(n, "R9 pdelay req link-local", {63'd0, n}, 64'd1);
    ingress(1'b0, 4'h3, 16'd40, 48'd0, o, n);
    check(n, "R9 pdelay resp link-local", {63'd0, n}, 64'd1);
    ingress(1'b0, 4'hA, 16'd40, 48'd0, o, n);
    check(n, "R9 pdelay resp follow-up link-local", {63'd0, n}, 64'd1);
    egress(1'b1, 4'h0, 16'd40, 48'd9, 64'h4, v, e, c);
    check(v && e && c == 64'h4, "R9 link-local never stored", c, 64'h4);
    ingress(1'b0, 4'h0, 16'd41, 48'd0, o, n);
    check(!n, "R9 SYNC forwarded", {63'd0, n}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_multicast();
    t_overwrite_direction();
    t_p2p();
    t_unicast();
    t_nonsync_egress();
    t_overflow();
    t_link_local();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule